// File: doc/BRIEF.md
# Serial Access Register Port

This block is the sequential side of a dual-ported video-style memory. It is a register file of `DEPTH` entries of `WIDTH` bits, reached only through an internal pointer that steps once per serial clock event. A transfer controller elsewhere on the chip issues transfer commands. A read transfer loads a whole row into the register and sets a start position. A write transfer hands the full register contents to the array side. A pseudo write changes only the port direction. The register is read or written one entry per serial step, starting from that position.

The direction of the serial port is not a pin. It follows the kind of the most recent completed transfer. Serial enable only gates the output driver and the write path; the pointer advances on every step either way. A real-time read transfer lets serial stepping go on through the old contents while the transfer is pending. The new row then appears at the start position on the very next step after completion.

A two-state controller handles the transfer cycle. `ST_IDLE` moves to `ST_XFER` when `xfer_start` is seen. It stays in `ST_XFER` until `xfer_done`, then returns to `ST_IDLE`. While in `ST_XFER`, steps are rejected unless the pending transfer is real-time. The direction is `DIR_IN` or `DIR_OUT` and is updated only on the `ST_XFER` to `ST_IDLE` transition.

Top module: `sam_port`

## Requirements
- R1: In output mode, each accepted `ser_step` makes `ser_dout` show the entry at the current pointer from the following clock edge, and the pointer then advances by one.
- R2: The pointer steps from `DEPTH-1` (255) to 0.
- R3: The start position `xfer_tap` is captured in the cycle `xfer_start` is accepted. The pointer takes that value when `xfer_done` completes the transfer.
- R4: `xfer_kind` encodes the transfer: 0 read, 1 real-time read, 2 write, 3 pseudo write. On completion, kinds 0 and 1 select output mode and kinds 2 and 3 select input mode. `ser_oe` is high only in output mode with `ser_en_n` low. The mode changes at no other time.
- R5: A pseudo write transfer raises no `row_we` and leaves the stored entries unchanged.
- R6: While `ser_en_n` is high, `ser_oe` is low and an input-mode step writes nothing, yet the pointer still advances.
- R7: In input mode with `ser_en_n` low, a step stores `ser_din` at the pointer. A write transfer raises `row_we` during its `xfer_done` cycle, with entry i on `row_out[i*WIDTH +: WIDTH]`.
- R8: After reset the port is in input mode (`ser_oe` low), the pointer is 0 and `seq_err` is low.
- R9: A step during a pending transfer that is not real-time is ignored: the pointer and data stay put, and `seq_err` is high in that cycle.
- R10: During a pending real-time read, steps go on reading the old contents. The first step after `xfer_done` outputs the new row entry at the start position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_step | input | 1 | One-cycle pulse per serial clock rising edge |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_din | input | WIDTH | Serial write data |
| ser_dout | output | WIDTH | Serial read data |
| ser_oe | output | 1 | Serial output driver enable |
| xfer_start | input | 1 | Transfer cycle begins |
| xfer_kind | input | 2 | Transfer type, sampled with `xfer_start` |
| xfer_tap | input | AW | Start position, sampled with `xfer_start` |
| xfer_done | input | 1 | Transfer cycle completes |
| row_in | input | DEPTH*WIDTH | Row loaded by a read transfer |
| row_out | output | DEPTH*WIDTH | Register contents for a write transfer |
| row_we | output | 1 | Row write strobe of a write transfer |
| seq_err | output | 1 | Step rejected during a transfer |

## Verification
A pointer that is off by one shows up on the very next serial read as a neighbouring row entry. It shows up on a later write transfer as data in a shifted slot of `row_out`. A wrong direction shows at once on `ser_oe`. A controller that is stuck in or out of `ST_XFER` shows on the next step, either as a spurious `seq_err` or as data that moves when it should not. Every bench read is chosen so that neighbouring entries differ, so any one-step slip is caught within one cycle.

// File: rtl/sam_pkg.sv
package sam_pkg;
    typedef enum logic [1:0] {
        XK_READ   = 2'd0,
        XK_RTREAD = 2'd1,
        XK_WRITE  = 2'd2,
        XK_PSEUDO = 2'd3
    } xkind_e;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } dir_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } xst_e;
endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl
    import sam_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_start,
    input  logic [1:0]    xfer_kind,
    input  logic [AW-1:0] xfer_tap,
    input  logic          xfer_done,
    input  logic          ser_step,
    output dir_e          dir,
    output logic [AW-1:0] tap_q,
    output logic          load_ptr,
    output logic          load_row,
    output logic          step_ok,
    output logic          viol,
    output logic          row_we
);
    xst_e   st;
    xkind_e kind_q;
    logic   done_ok;
    logic   rt_pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            kind_q <= XK_READ;
            tap_q  <= '0;
            dir    <= DIR_IN;
        end else begin
            unique case (st)
                ST_IDLE: if (xfer_start) begin
                    st     <= ST_XFER;
                    kind_q <= xkind_e'(xfer_kind);
                    tap_q  <= xfer_tap;
                end
                ST_XFER: if (xfer_done) begin
                    st  <= ST_IDLE;
                    dir <= (kind_q == XK_READ || kind_q == XK_RTREAD) ? DIR_OUT : DIR_IN;
                end
            endcase
        end
    end

    always_comb begin
        done_ok    = 1'b0;
        rt_pending = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_XFER: begin
                done_ok    = xfer_done;
                rt_pending = (kind_q == XK_RTREAD);
            end
        endcase
        load_ptr = done_ok;
        load_row = done_ok && (kind_q == XK_READ || kind_q == XK_RTREAD);
        row_we   = done_ok && (kind_q == XK_WRITE);
        step_ok  = ser_step && (st == ST_IDLE || rt_pending);
        viol     = ser_step && (st == ST_XFER) && !rt_pending;
    end

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_ok |=> $stable(dir));

    // R7
    wr_leaves_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_we |=> (st == ST_IDLE && dir == DIR_IN));
endmodule

// File: rtl/sam_ptr.sv
module sam_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          load,
    input  logic [AW-1:0] tap,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= tap;
        else if (adv)  ptr <= ptr + 1'b1;
    end

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && ptr == TOP) |=> (ptr == '0));

    // R3
    tap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(tap)));
endmodule

// File: rtl/sam_store.sv
module sam_store
    import sam_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          ptr,
    input  logic                   step_ok,
    input  dir_e                   dir,
    input  logic                   en_n,
    input  logic [WIDTH-1:0]       din,
    input  logic                   load_row,
    input  logic [DEPTH*WIDTH-1:0] row_in,
    output logic [WIDTH-1:0]       dout,
    output logic [DEPTH*WIDTH-1:0] row_out
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic             wr;

    assign wr = step_ok && (dir == DIR_IN) && !en_n;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [AW-1:0] IDX = AW'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  mem[g] <= '0;
            else if (load_row)           mem[g] <= row_in[g*WIDTH +: WIDTH];
            else if (wr && ptr == IDX)   mem[g] <= din;
        end
        assign row_out[g*WIDTH +: WIDTH] = mem[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             dout <= '0;
        else if (step_ok && dir == DIR_OUT)     dout <= mem[ptr];
    end
endmodule

// File: rtl/sam_port.sv
module sam_port
    import sam_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_step,
    input  logic                   ser_en_n,
    input  logic [WIDTH-1:0]       ser_din,
    output logic [WIDTH-1:0]       ser_dout,
    output logic                   ser_oe,
    input  logic                   xfer_start,
    input  logic [1:0]             xfer_kind,
    input  logic [AW-1:0]          xfer_tap,
    input  logic                   xfer_done,
    input  logic [DEPTH*WIDTH-1:0] row_in,
    output logic [DEPTH*WIDTH-1:0] row_out,
    output logic                   row_we,
    output logic                   seq_err
);
    dir_e          dir;
    logic [AW-1:0] tap_q;
    logic [AW-1:0] ptr;
    logic          load_ptr, load_row, step_ok;

    sam_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .xfer_start(xfer_start), .xfer_kind(xfer_kind), .xfer_tap(xfer_tap),
        .xfer_done(xfer_done), .ser_step(ser_step),
        .dir(dir), .tap_q(tap_q), .load_ptr(load_ptr), .load_row(load_row),
        .step_ok(step_ok), .viol(seq_err), .row_we(row_we)
    );

    sam_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv(step_ok), .load(load_ptr),
        .tap(tap_q), .ptr(ptr)
    );

    sam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .ptr(ptr), .step_ok(step_ok), .dir(dir),
        .en_n(ser_en_n), .din(ser_din), .load_row(load_row), .row_in(row_in),
        .dout(ser_dout), .row_out(row_out)
    );

    assign ser_oe = (dir == DIR_OUT) && !ser_en_n;

    // R9
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !xfer_done) |=> (ptr == $past(ptr) && $stable(ser_dout)));

    // R6
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en_n |-> !ser_oe);
endmodule

// File: tb/sim_sam_port.sv
module sim_sam_port;
    localparam int DEPTH = 256;
    localparam int WIDTH = 8;
    localparam int AW    = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   ser_step = 1'b0;
    logic                   ser_en_n = 1'b0;
    logic [WIDTH-1:0]       ser_din = '0;
    logic [WIDTH-1:0]       ser_dout;
    logic                   ser_oe;
    logic                   xfer_start = 1'b0;
    logic [1:0]             xfer_kind = 2'd0;
    logic [AW-1:0]          xfer_tap = '0;
    logic                   xfer_done = 1'b0;
    logic [DEPTH*WIDTH-1:0] row_in = '0;
    logic [DEPTH*WIDTH-1:0] row_out;
    logic                   row_we;
    logic                   seq_err;

    int total = 0;
    int bad   = 0;
    logic we_seen;
    logic [DEPTH*WIDTH-1:0] row_seen;
    logic err_seen;

    always #4 clk = ~clk;

    sam_port #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_step(ser_step), .ser_en_n(ser_en_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_oe(ser_oe),
        .xfer_start(xfer_start), .xfer_kind(xfer_kind), .xfer_tap(xfer_tap),
        .xfer_done(xfer_done), .row_in(row_in), .row_out(row_out),
        .row_we(row_we), .seq_err(seq_err)
    );

    function automatic logic [7:0] rowv(input int sel, input int i);
        case (sel)
            0:       rowv = 8'(i) ^ 8'h5A;
            1:       rowv = 8'(i * 3 + 1);
            default: rowv = 8'(i * 7) ^ 8'hC3;
        endcase
    endfunction

    function automatic logic [DEPTH*WIDTH-1:0] rowfill(input int sel);
        logic [DEPTH*WIDTH-1:0] r;
        for (int i = 0; i < DEPTH; i++) r[i*WIDTH +: WIDTH] = rowv(sel, i);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] d);
        @(posedge clk); #1 ser_step = 1'b1; ser_din = d;
        #2 err_seen = seq_err;
        @(posedge clk); #1 ser_step = 1'b0;
        #2;
    endtask

    task automatic xbegin(input logic [1:0] k, input logic [7:0] t);
        @(posedge clk); #1 xfer_start = 1'b1; xfer_kind = k; xfer_tap = t;
        @(posedge clk); #1 xfer_start = 1'b0; xfer_tap = ~t;
    endtask

    task automatic xend();
        @(posedge clk); #1 xfer_done = 1'b1;
        #2 we_seen = row_we; row_seen = row_out;
        @(posedge clk); #1 xfer_done = 1'b0;
        #2;
    endtask

    task automatic t_reset();
        #3;
        chk("R8 oe after reset", 32'(ser_oe), 0);
        chk("R8 err after reset", 32'(seq_err), 0);
        chk("R8 row_we after reset", 32'(row_we), 0);
        // pointer 0 in input mode: first write lands in entry 0
        step(8'hE7);
        xbegin(2'd2, 8'd0); xend();
        chk("R8 pointer starts at 0", 32'(row_seen[0 +: 8]), 32'h00E7);
        chk("R8 entry 1 untouched", 32'(row_seen[8 +: 8]), 0);
    endtask

    task automatic t_read_wrap();
        row_in = rowfill(0);
        xbegin(2'd0, 8'd254); xend();
        chk("R4 oe in output mode", 32'(ser_oe), 1);
        step(8'h00); chk("R1 R3 first at tap", 32'(ser_dout), 32'(rowv(0, 254)));
        step(8'h00); chk("R1 next entry", 32'(ser_dout), 32'(rowv(0, 255)));
        step(8'h00); chk("R2 wrap to 0", 32'(ser_dout), 32'(rowv(0, 0)));
        step(8'h00); chk("R2 after wrap", 32'(ser_dout), 32'(rowv(0, 1)));
    endtask

    task automatic t_enable_gate();
        @(posedge clk); #1 ser_en_n = 1'b1;
        #2 chk("R6 oe low when disabled", 32'(ser_oe), 0);
        step(8'h00); step(8'h00);
        @(posedge clk); #1 ser_en_n = 1'b0;
        step(8'h00); chk("R6 pointer advanced while disabled", 32'(ser_dout), 32'(rowv(0, 4)));
    endtask

    task automatic t_pseudo_and_write();
        row_in = rowfill(1);
        xbegin(2'd3, 8'd10); xend();
        chk("R5 no row_we on pseudo", 32'(we_seen), 0);
        chk("R4 input mode after pseudo", 32'(ser_oe), 0);
        step(8'hC0); step(8'hC1); step(8'hC2);
        @(posedge clk); #1 ser_en_n = 1'b1;
        step(8'hEE);
        @(posedge clk); #1 ser_en_n = 1'b0;
        step(8'hD0);
        xbegin(2'd2, 8'd0); xend();
        chk("R7 row_we on write transfer", 32'(we_seen), 1);
        chk("R7 entry 10", 32'(row_seen[10*8 +: 8]), 32'h00C0);
        chk("R7 entry 12", 32'(row_seen[12*8 +: 8]), 32'h00C2);
        chk("R6 write blocked entry 13", 32'(row_seen[13*8 +: 8]), 32'(rowv(0, 13)));
        chk("R6 entry 14 after skip", 32'(row_seen[14*8 +: 8]), 32'h00D0);
        chk("R5 pseudo kept contents", 32'(row_seen[9*8 +: 8]), 32'(rowv(0, 9)));
        chk("R4 input mode after write", 32'(ser_oe), 0);
        #5 chk("R7 row_we only one cycle", 32'(row_we), 0);
    endtask

    task automatic t_violation();
        row_in = rowfill(1);
        xbegin(2'd0, 8'd20);
        step(8'h00);
        chk("R9 seq_err on step in transfer", 32'(err_seen), 1);
        xend();
        step(8'h00);
        chk("R9 step ignored, first at tap", 32'(ser_dout), 32'(rowv(1, 20)));
        chk("R9 no error when idle", 32'(err_seen), 0);
    endtask

    task automatic t_realtime();
        row_in = rowfill(2);
        xbegin(2'd1, 8'd100);
        step(8'h00);
        chk("R10 old row during transfer", 32'(ser_dout), 32'(rowv(1, 21)));
        chk("R10 no error on real-time", 32'(err_seen), 0);
        step(8'h00);
        chk("R10 old row continues", 32'(ser_dout), 32'(rowv(1, 22)));
        xend();
        step(8'h00);
        chk("R10 new row at tap", 32'(ser_dout), 32'(rowv(2, 100)));
        step(8'h00);
        chk("R10 new row next", 32'(ser_dout), 32'(rowv(2, 101)));
    endtask

    initial begin
        #20 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_wrap();
        t_enable_gate();
        t_pseudo_and_write();
        t_violation();
        t_realtime();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule